// File: doc/BRIEF.md
# Serial ADC Output Frame Emulator

This block plays the digital side of a small serial sampling converter. It is meant to sit in front of a reader under test, either in simulation or in an FPGA model of the converter. The reader drives an active-low chip select and a serial clock. The block answers with a 16-bit frame on a serial data line that is enabled only while a frame is live. It also reports whether the modelled sampler is holding or tracking. The sample value comes from a parallel port and is taken to be already in two's complement form.

Every input is sampled by a fast system clock. Each edge of chip select or the serial clock takes effect one system-clock cycle after it is first seen. The one exception is the output enable: it is also gated directly by chip select, so a rising chip select releases the line without waiting for a register. A mode input picks a 12-bit frame or a 10-bit frame. In both cases four zeros lead the data. The 10-bit frame also carries two trailing zeros.

Top module: `sar_frame_emu`

## Requirements
- R1: One cycle after a falling chip select is seen, the block captures `sample` and `narrow`, sets `hold` to 1 (1 = hold, 0 = track) and drives `sdata_oe` to 1.
- R2: The first frame bit, a leading zero, is on `sdata` from the chip-select fall. Each later serial-clock fall presents the next frame bit, MSB first. `sdata` reads 0 whenever `sdata_oe` is 0.
- R3: With `narrow` = 0 the frame is four zeros followed by `sample[11:0]`, MSB first.
- R4: With `narrow` = 1 the frame is four zeros, then `sample[9:0]` MSB first, then two zeros.
- R5: `hold` returns to 0 one cycle after the first serial-clock rise that follows the 13th serial-clock fall of a frame.
- R6: `sdata_oe` goes to 0 one cycle after the 16th serial-clock fall of a frame.
- R7: A chip-select rise before the 16th fall drops `sdata_oe` as soon as `cs_n` is high, returns `hold` to 0 and abandons the frame.
- R8: Serial-clock edges while `cs_n` is high change neither output. The next frame still starts from its first bit.
- R9: After the 16th fall, further serial-clock edges leave `sdata_oe` at 0 until chip select rises and falls again. The next frame is a complete, fresh frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the reader |
| cs_n | input | 1 | Active-low chip select from the reader |
| narrow | input | 1 | Frame variant: 0 = 12-bit data, 1 = 10-bit data with two trailing zeros |
| sample | input | 12 | Two's complement sample word, captured at the chip-select fall |
| sdata | output | 1 | Serial frame bit (0 when not enabled) |
| sdata_oe | output | 1 | Output enable for the serial data line |
| hold | output | 1 | Sampler status: 1 = hold, 0 = track |

## Verification
The hardest case is a frame cut short in a chosen phase. The bench must raise chip select after an exact number of serial-clock falls: once before the 13th fall, while the sampler is still holding, and once after it. It must then confirm that the line is released, that the sampler tracks, and that the next frame starts at its first bit. The bench drives serial-clock falls one at a time and raises chip select after 5 and after 14 falls. It also sends extra clock edges after a full frame and while chip select is high. A reference model in the bench tracks the expected enable, status and bit for every system-clock cycle.

// File: rtl/sar_frame_pkg.sv
package sar_frame_pkg;
  localparam int FRAME_BITS  = 16;
  localparam int WIDE_BITS   = 12;
  localparam int NARROW_BITS = 10;
  localparam int TRACK_FALLS = 13;
endpackage

// File: rtl/sfe_edge_det.sv
module sfe_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic cs_fall,
  output logic sclk_fall,
  output logic sclk_rise
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign cs_fall   = cs_q & ~cs_n;
  assign sclk_fall = sclk_q & ~sclk;
  assign sclk_rise = ~sclk_q & sclk;
endmodule

// File: rtl/sfe_frame_shift.sv
module sfe_frame_shift #(
  parameter int FRAME_W  = 16,
  parameter int WIDE_W   = 12,
  parameter int NARROW_W = 10,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_fall,
  input  logic              sclk_fall,
  input  logic              narrow,
  input  logic [WIDE_W-1:0] sample,
  output logic              bit_out,
  output logic              active,
  output logic [CNT_W-1:0]  cnt
);
  localparam int LEAD_W = FRAME_W - WIDE_W;
  localparam int TAIL_W = WIDE_W - NARROW_W;

  logic [FRAME_W-1:0] load_word, sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;

  always_comb begin
    if (narrow) load_word = {{LEAD_W{1'b0}}, sample[NARROW_W-1:0], {TAIL_W{1'b0}}};
    else        load_word = {{LEAD_W{1'b0}}, sample};
  end

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (cs_n) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (cs_fall) begin
      sh_d  = load_word;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (sclk_fall && act_q) begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
      act_d = (cnt_q != CNT_W'(FRAME_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign bit_out = sh_q[FRAME_W-1];
  assign active  = act_q;
  assign cnt     = cnt_q;

  // R1
  load_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !cs_n) |=> (act_q && cnt_q == '0));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_fall && sclk_fall && act_q) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0 && !act_q));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));
endmodule

// File: rtl/sfe_track_hold.sv
module sfe_track_hold #(
  parameter int CNT_W      = 5,
  parameter int TRACK_EDGE = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic [CNT_W-1:0] cnt,
  output logic             hold
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (cs_n)                                          hold_d = 1'b0;
    else if (cs_fall)                                  hold_d = 1'b1;
    else if (sclk_rise && cnt >= CNT_W'(TRACK_EDGE))   hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q;

  // R1
  hold_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !cs_n) |=> hold_q);
  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !cs_fall && sclk_rise && cnt >= CNT_W'(TRACK_EDGE)) |=> !hold_q);
  // R7
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !hold_q);
endmodule

// File: rtl/sar_frame_emu.sv
module sar_frame_emu
  import sar_frame_pkg::*;
#(
  parameter int FRAME_W    = FRAME_BITS,
  parameter int WIDE_W     = WIDE_BITS,
  parameter int NARROW_W   = NARROW_BITS,
  parameter int TRACK_EDGE = TRACK_FALLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              narrow,
  input  logic [WIDE_W-1:0] sample,
  output logic              sdata,
  output logic              sdata_oe,
  output logic              hold
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic             cs_fall, sclk_fall, sclk_rise;
  logic             bit_out, active;
  logic [CNT_W-1:0] cnt;

  sfe_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .cs_fall(cs_fall), .sclk_fall(sclk_fall), .sclk_rise(sclk_rise)
  );

  sfe_frame_shift #(
    .FRAME_W(FRAME_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .narrow(narrow), .sample(sample),
    .bit_out(bit_out), .active(active), .cnt(cnt)
  );

  sfe_track_hold #(
    .CNT_W(CNT_W), .TRACK_EDGE(TRACK_EDGE)
  ) u_th (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .cnt(cnt), .hold(hold)
  );

  assign sdata_oe = active & ~cs_n;
  assign sdata    = bit_out & sdata_oe;

  // R6
  release_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(FRAME_W)) |-> !sdata_oe);
endmodule

// File: tb/sar_frame_emu_test.sv
module sar_frame_emu_test;
  localparam int PERIOD = 10;

  logic        clk, rst_n, sclk, cs_n, narrow;
  logic [11:0] sample;
  logic        sdata, sdata_oe, hold;

  typedef struct {
    logic  oe;
    logic  sd;
    logic  hl;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  logic        m_prev_s, m_prev_c, m_act, m_hold;
  int          m_cnt;
  logic [15:0] m_frame;

  sar_frame_emu uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .narrow(narrow),
    .sample(sample), .sdata(sdata), .sdata_oe(sdata_oe), .hold(hold)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic step(input logic s, input logic c, input string req);
    exp_t  e;
    string tag;
    tag = req;
    @(negedge clk);
    sclk = s;
    cs_n = c;
    if (c) begin
      if (!m_prev_c && m_act) tag = "R7";
      m_cnt = 0; m_act = 1'b0; m_hold = 1'b0;
    end else if (m_prev_c) begin
      m_cnt = 0; m_act = 1'b1; m_hold = 1'b1; tag = "R1 R2";
      if (narrow) m_frame = {4'h0, sample[9:0], 2'b00};
      else        m_frame = {4'h0, sample};
    end else begin
      if (m_prev_s && !s && m_act) begin
        m_cnt++;
        if (m_cnt == 16) begin m_act = 1'b0; tag = "R6"; end
      end
      if (!m_prev_s && s && m_cnt >= 13 && m_hold) begin
        m_hold = 1'b0; tag = "R5";
      end
    end
    m_prev_s = s;
    m_prev_c = c;
    e.oe  = m_act && !c;
    e.sd  = e.oe ? m_frame[15 - m_cnt] : 1'b0;
    e.hl  = m_hold;
    e.req = tag;
    exp_q.push_back(e);
  endtask

  task automatic frame(input logic [11:0] smp, input logic nar, input int falls,
                       input int extra, input string req);
    sample = smp;
    narrow = nar;
    step(1'b0, 1'b0, req);
    for (int i = 0; i < falls; i++) begin
      step(1'b1, 1'b0, req);
      step(1'b0, 1'b0, req);
    end
    for (int i = 0; i < extra; i++) begin
      step(1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, "R9");
    end
    step(1'b0, 1'b1, req);
    step(1'b0, 1'b1, req);
  endtask

  // monitor: compares outputs just after every active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (sdata_oe !== e.oe || sdata !== e.sd || hold !== e.hl) begin
          errors++;
          $display("FAIL %s: oe/sdata/hold = %b%b%b expected %b%b%b at %0t",
                   e.req, sdata_oe, sdata, hold, e.oe, e.sd, e.hl, $time);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; narrow = 1'b0; sample = '0;
    m_prev_s = 1'b0; m_prev_c = 1'b1; m_act = 1'b0; m_hold = 1'b0;
    m_cnt = 0; m_frame = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b1, "R1 reset");
    // R8: serial clock toggles with chip select high
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, "R8");
      step(1'b0, 1'b1, "R8");
    end
    frame(12'hA5C, 1'b0, 16, 0, "R3");
    frame(12'h2B3, 1'b1, 16, 0, "R4");
    frame(12'h800, 1'b0, 16, 3, "R9");
    frame(12'h7FF, 1'b0, 5, 0, "R7");
    frame(12'h123, 1'b0, 14, 0, "R7");
    for (int i = 0; i < 2; i++) begin
      step(1'b1, 1'b1, "R8");
      step(1'b0, 1'b1, "R8");
    end
    frame(12'hFFF, 1'b1, 16, 0, "R4");
    frame(12'h3C6, 1'b0, 16, 2, "R9");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule